// File: doc/BRIEF.md
# Four-Slot Averaging Conversion Sequencer

This block is the control logic for one 12-bit analogue-to-digital converter that is shared by four logical slots, A to D. Software programs each slot through two configuration words: an enable, a one-shot flag, an averaging switch, a 4-bit physical input select and a 2-bit averaging count. The sequencer serves the enabled slots one at a time, with A having the highest priority. For each conversion it requests samples from the converter over a request/valid handshake, adds them up and stores the average as a 12-bit result. Results are packed two slots to a word.

Each finished conversion raises a done flag for its slot. A converter that stops answering raises a timeout flag instead. Both kinds of flag sit in one status word. Software clears a flag by writing 0 to its bit. One mask decides which events may set a flag at all, and a second mask decides which flags drive the interrupt line. A global control word powers the sequencer up and down. Registers are reached through a simple single-cycle write port and a combinational read port.

Top module: `conv_seq`

## Requirements
- R1: After reset the status word reads 0, both result words read 0, the global word (0x080) reads 0x8000_0002, and `cnv_req` and `irq` are low.
- R2: No conversion starts unless the global word has bit 0 set and both bit 1 and bit 31 clear.
- R3: Slot i has its first word at 0x20*i and its second word at 0x20*i+0x10. In the first word, bit 31 is enable, bit 30 is one-shot, bit 29 is averaging on, and bits 27:24 are the input select. In the second word, bits 13:12 are the averaging count. While the slot is converting, `cnv_sel` equals its input select.
- R4: With averaging on, a conversion takes 4<<count samples and stores the sum shifted right by count+2. With averaging off, it takes one sample and stores that sample.
- R5: Word 0x0C0 holds slot A in bits 11:0 and slot B in bits 27:16. Word 0x0D0 holds C and D in the same layout. All other bits read 0.
- R6: In one-shot mode, the slot's enable bit clears in the same cycle that its result is stored, and its done flag is set.
- R7: When several slots are enabled, they are served one conversion at a time in the order A, B, C, D.
- R8: If no valid sample arrives within TMO_CYCLES clock cycles, the conversion is abandoned. The slot's timeout flag (status bit 16+i) is set, its result is left unchanged, no done flag is set, and a one-shot slot's enable bit clears.
- R9: Status word 0x0B0 carries done flags in bits 11:8 and timeout flags in bits 19:16. Reading it changes nothing. Writing 0 to a bit clears that flag and writing 1 leaves it as it was. A new event in the same cycle as a clear wins.
- R10: A flag is set only if its bit in the event mask (0x0A0, same bit positions) is 1. `irq` is the OR of status bits whose bit in the line mask (0x090) is 1.
- R11: In continuous mode (one-shot clear), the slot keeps its enable bit and converts again and again, raising a done flag each time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| cnv_req | output | 1 | Sample request to the converter, held high until a sample arrives |
| cnv_sel | output | 4 | Physical input select for the current request |
| cnv_valid | input | 1 | Converter returns a sample this cycle |
| cnv_code | input | 12 | Sample code |
| irq | output | 1 | Interrupt line |

## Verification
The hardest case to reach from the ports is two slots waiting at the same moment. Every register write takes a cycle, so the first slot written would start on its own before the second one is enabled. The bench therefore holds the global word in power-down, enables slots A and C, and only then powers up. The order of `cnv_sel` values at the rising edges of `cnv_req` then shows the priority. Timeouts come from a converter model that is switched off, so `cnv_req` stays unanswered for the whole timeout window.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    localparam int NSLOT       = 4;
    localparam int SLOT_W      = $clog2(NSLOT);
    localparam int CODE_W      = 12;
    localparam int SEL_W       = 4;
    localparam int CNT_W       = 2;
    localparam int ADDR_W      = 9;
    localparam int DATA_W      = 32;
    localparam int MAX_LOG2    = (1 << CNT_W) + 1;          // 32 samples
    localparam int ACC_W       = CODE_W + MAX_LOG2;
    localparam int SMP_W       = MAX_LOG2 + 1;
    localparam int SLOT_STRIDE = 'h20;
    localparam int CFG2_OFS    = 'h10;

    localparam logic [ADDR_W-1:0] A_GLOBAL = 9'h080;
    localparam logic [ADDR_W-1:0] A_LINE   = 9'h090;
    localparam logic [ADDR_W-1:0] A_EVENT  = 9'h0A0;
    localparam logic [ADDR_W-1:0] A_STAT   = 9'h0B0;
    localparam logic [ADDR_W-1:0] A_RES_LO = 9'h0C0;
    localparam logic [ADDR_W-1:0] A_RES_HI = 9'h0D0;

    localparam int B_EN     = 31;
    localparam int B_ONCE   = 30;
    localparam int B_AVG    = 29;
    localparam int B_SEL    = 24;
    localparam int B_CNT    = 12;
    localparam int B_DONE   = 8;
    localparam int B_TMO    = 16;
    localparam int B_RUN    = 0;
    localparam int B_PDOWN  = 1;
    localparam int B_CDOWN  = 31;

    typedef struct packed {
        logic             en;
        logic             once;
        logic             avg;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
    } slot_cfg_t;

    typedef enum logic {ST_IDLE, ST_WAIT} eng_state_t;

    function automatic logic [ADDR_W-1:0] slot_base(input int i);
        return ADDR_W'(i * SLOT_STRIDE);
    endfunction

    // lowest index wins
    function automatic logic [SLOT_W-1:0] pick_slot(input logic [NSLOT-1:0] want);
        logic [SLOT_W-1:0] p;
        p = '0;
        for (int i = NSLOT - 1; i >= 0; i--)
            if (want[i]) p = SLOT_W'(i);
        return p;
    endfunction

    function automatic logic [2:0] log2_samples(input slot_cfg_t c);
        return c.avg ? 3'(c.cnt) + 3'd2 : 3'd0;
    endfunction

endpackage

// File: rtl/conv_seq_regs.sv
module conv_seq_regs
    import conv_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output slot_cfg_t           cfg [NSLOT],
    output logic                go_ok,
    input  logic [NSLOT-1:0]    done_p,
    input  logic [NSLOT-1:0]    tmo_p,
    input  logic [NSLOT-1:0]    clr_en,
    input  logic                res_we,
    input  logic [SLOT_W-1:0]   res_slot,
    input  logic [CODE_W-1:0]   res_val,
    output logic [DATA_W-1:0]   status,
    output logic                irq
);

    slot_cfg_t          cfg_q [NSLOT];
    logic [CODE_W-1:0]  res_q [NSLOT];
    logic               g_run, g_pdown, g_cdown;
    logic [NSLOT-1:0]   line_done, line_tmo, evt_done, evt_tmo;
    logic [NSLOT-1:0]   done_f, tmo_f;
    logic               stat_we;

    assign stat_we = reg_we && (reg_addr == A_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOT; i++) begin
                cfg_q[i] <= '0;
                res_q[i] <= '0;
            end
            g_run     <= 1'b0;
            g_pdown   <= 1'b1;
            g_cdown   <= 1'b1;
            line_done <= '0;
            line_tmo  <= '0;
            evt_done  <= '0;
            evt_tmo   <= '0;
            done_f    <= '0;
            tmo_f     <= '0;
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (clr_en[i])
                    cfg_q[i].en <= 1'b0;
                if (reg_we && reg_addr == slot_base(i)) begin
                    cfg_q[i].en   <= reg_wdata[B_EN];
                    cfg_q[i].once <= reg_wdata[B_ONCE];
                    cfg_q[i].avg  <= reg_wdata[B_AVG];
                    cfg_q[i].sel  <= reg_wdata[B_SEL +: SEL_W];
                end
                if (reg_we && reg_addr == slot_base(i) + ADDR_W'(CFG2_OFS))
                    cfg_q[i].cnt <= reg_wdata[B_CNT +: CNT_W];
            end
            if (res_we)
                res_q[res_slot] <= res_val;
            if (reg_we && reg_addr == A_GLOBAL) begin
                g_run   <= reg_wdata[B_RUN];
                g_pdown <= reg_wdata[B_PDOWN];
                g_cdown <= reg_wdata[B_CDOWN];
            end
            if (reg_we && reg_addr == A_LINE) begin
                line_done <= reg_wdata[B_DONE +: NSLOT];
                line_tmo  <= reg_wdata[B_TMO  +: NSLOT];
            end
            if (reg_we && reg_addr == A_EVENT) begin
                evt_done <= reg_wdata[B_DONE +: NSLOT];
                evt_tmo  <= reg_wdata[B_TMO  +: NSLOT];
            end
            done_f <= (stat_we ? (done_f & reg_wdata[B_DONE +: NSLOT]) : done_f)
                      | (done_p & evt_done);
            tmo_f  <= (stat_we ? (tmo_f & reg_wdata[B_TMO +: NSLOT]) : tmo_f)
                      | (tmo_p & evt_tmo);
        end
    end

    assign cfg    = cfg_q;
    assign go_ok  = g_run && !g_pdown && !g_cdown;
    assign irq    = |(done_f & line_done) || |(tmo_f & line_tmo);

    always_comb begin
        status = '0;
        status[B_DONE +: NSLOT] = done_f;
        status[B_TMO  +: NSLOT] = tmo_f;
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (reg_addr == slot_base(i)) begin
                reg_rdata[B_EN]              = cfg_q[i].en;
                reg_rdata[B_ONCE]            = cfg_q[i].once;
                reg_rdata[B_AVG]             = cfg_q[i].avg;
                reg_rdata[B_SEL +: SEL_W]    = cfg_q[i].sel;
            end
            if (reg_addr == slot_base(i) + ADDR_W'(CFG2_OFS))
                reg_rdata[B_CNT +: CNT_W] = cfg_q[i].cnt;
        end
        case (reg_addr)
            A_GLOBAL: begin
                reg_rdata[B_RUN]   = g_run;
                reg_rdata[B_PDOWN] = g_pdown;
                reg_rdata[B_CDOWN] = g_cdown;
            end
            A_LINE: begin
                reg_rdata[B_DONE +: NSLOT] = line_done;
                reg_rdata[B_TMO  +: NSLOT] = line_tmo;
            end
            A_EVENT: begin
                reg_rdata[B_DONE +: NSLOT] = evt_done;
                reg_rdata[B_TMO  +: NSLOT] = evt_tmo;
            end
            A_STAT:   reg_rdata = status;
            A_RES_LO: reg_rdata = {4'b0, res_q[1], 4'b0, res_q[0]};
            A_RES_HI: reg_rdata = {4'b0, res_q[3], 4'b0, res_q[2]};
            default: ;
        endcase
    end

endmodule

// File: rtl/conv_seq_engine.sv
module conv_seq_engine
    import conv_seq_pkg::*;
#(
    parameter int TMO_CYCLES = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  slot_cfg_t          cfg [NSLOT],
    input  logic               go_ok,
    output logic               cnv_req,
    output logic [SEL_W-1:0]   cnv_sel,
    input  logic               cnv_valid,
    input  logic [CODE_W-1:0]  cnv_code,
    output logic [NSLOT-1:0]   done_p,
    output logic [NSLOT-1:0]   tmo_p,
    output logic [NSLOT-1:0]   clr_en,
    output logic               res_we,
    output logic [SLOT_W-1:0]  res_slot,
    output logic [CODE_W-1:0]  res_val
);

    localparam int TMO_W = $clog2(TMO_CYCLES + 1);

    eng_state_t          state;
    logic [SLOT_W-1:0]   slot_q;
    logic [SEL_W-1:0]    sel_q;
    logic [2:0]          shift_q;
    logic                once_q;
    logic [SMP_W-1:0]    smp_q;
    logic [ACC_W-1:0]    acc_q;
    logic [TMO_W-1:0]    tmo_q;
    logic [NSLOT-1:0]    want;
    logic [ACC_W-1:0]    acc_nx;
    logic                last, finish, expire;
    logic [SLOT_W-1:0]   pick;

    always_comb
        for (int i = 0; i < NSLOT; i++) want[i] = cfg[i].en;

    assign pick   = pick_slot(want);
    assign acc_nx = acc_q + ACC_W'(cnv_code);
    assign last   = (smp_q == SMP_W'((1 << shift_q) - 1));
    assign finish = (state == ST_WAIT) && cnv_valid && last;
    assign expire = (state == ST_WAIT) && !cnv_valid && (tmo_q == TMO_W'(TMO_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            slot_q  <= '0;
            sel_q   <= '0;
            shift_q <= '0;
            once_q  <= 1'b0;
            smp_q   <= '0;
            acc_q   <= '0;
            tmo_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (go_ok && |want) begin
                    state   <= ST_WAIT;
                    slot_q  <= pick;
                    sel_q   <= cfg[pick].sel;
                    shift_q <= log2_samples(cfg[pick]);
                    once_q  <= cfg[pick].once;
                    smp_q   <= '0;
                    acc_q   <= '0;
                    tmo_q   <= '0;
                end
                ST_WAIT: begin
                    if (cnv_valid) begin
                        tmo_q <= '0;
                        acc_q <= acc_nx;
                        smp_q <= smp_q + 1'b1;
                        if (last) state <= ST_IDLE;
                    end else if (expire) begin
                        state <= ST_IDLE;
                    end else begin
                        tmo_q <= tmo_q + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        done_p = '0;
        tmo_p  = '0;
        done_p[slot_q] = finish;
        tmo_p[slot_q]  = expire;
        clr_en = (done_p | tmo_p) & {NSLOT{once_q}};
    end

    assign cnv_req  = (state == ST_WAIT);
    assign cnv_sel  = sel_q;
    assign res_we   = finish;
    assign res_slot = slot_q;
    assign res_val  = CODE_W'(acc_nx >> shift_q);

endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_seq_pkg::*;
#(
    parameter int TMO_CYCLES = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                cnv_req,
    output logic [SEL_W-1:0]    cnv_sel,
    input  logic                cnv_valid,
    input  logic [CODE_W-1:0]   cnv_code,
    output logic                irq
);

    slot_cfg_t          cfg [NSLOT];
    logic               go_ok;
    logic [NSLOT-1:0]   done_p, tmo_p, clr_en;
    logic               res_we;
    logic [SLOT_W-1:0]  res_slot;
    logic [CODE_W-1:0]  res_val;
    logic [DATA_W-1:0]  status;

    conv_seq_regs u_regs (
        .clk, .rst, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .cfg, .go_ok, .done_p, .tmo_p, .clr_en,
        .res_we, .res_slot, .res_val, .status, .irq
    );

    conv_seq_engine #(.TMO_CYCLES(TMO_CYCLES)) u_engine (
        .clk, .rst, .cfg, .go_ok, .cnv_req, .cnv_sel, .cnv_valid, .cnv_code,
        .done_p, .tmo_p, .clr_en, .res_we, .res_slot, .res_val
    );

endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk
    import conv_seq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                reg_we,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                cnv_req,
    input logic [SEL_W-1:0]    cnv_sel,
    input logic                go_ok,
    input logic [NSLOT-1:0]    done_p,
    input logic [NSLOT-1:0]    tmo_p,
    input logic [DATA_W-1:0]   status
);

    // R2: a request only begins after the global word allowed it
    p_start_gated_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv_req) |-> $past(go_ok));

    // R3: the input select holds while a request is outstanding
    p_sel_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (cnv_req && $past(cnv_req)) |-> $stable(cnv_sel));

    // R7: at most one slot finishes or times out per cycle
    p_one_event_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done_p | tmo_p));

    // R9: a flag drops only after a write to the status word
    p_clear_by_write_r9: assert property (@(posedge clk) disable iff (rst)
        ((~status & $past(status)) != '0) |-> $past(reg_we && reg_addr == A_STAT));

    // R6: a done flag rises only after its slot finished
    p_done_source_r6: assert property (@(posedge clk) disable iff (rst)
        (status[B_DONE +: NSLOT] & ~$past(status[B_DONE +: NSLOT]) & ~$past(done_p)) == '0);

    // R8: a timeout flag rises only after its slot expired
    p_tmo_source_r8: assert property (@(posedge clk) disable iff (rst)
        (status[B_TMO +: NSLOT] & ~$past(status[B_TMO +: NSLOT]) & ~$past(tmo_p)) == '0);

endmodule

bind conv_seq conv_seq_chk u_chk (
    .clk, .rst, .reg_we, .reg_addr, .cnv_req, .cnv_sel,
    .go_ok, .done_p, .tmo_p, .status
);

// File: tb/test_conv_seq.sv
module test_conv_seq;
    import conv_seq_pkg::*;

    localparam int TMO = 64;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               reg_we = 1'b0;
    logic [ADDR_W-1:0]  reg_addr = '0;
    logic [DATA_W-1:0]  reg_wdata = '0;
    logic [DATA_W-1:0]  reg_rdata;
    logic               cnv_req;
    logic [SEL_W-1:0]   cnv_sel;
    logic               cnv_valid = 1'b0;
    logic [CODE_W-1:0]  cnv_code = '0;
    logic               irq;

    always #4 clk = ~clk;

    conv_seq #(.TMO_CYCLES(TMO)) i_conv_seq (
        .clk, .rst, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .cnv_req, .cnv_sel, .cnv_valid, .cnv_code, .irq
    );

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    // converter model and request monitor, on the falling edge
    bit          model_on = 1;
    bit          par = 0;
    logic [11:0] v0 = '0, v1 = '0;
    logic [3:0]  seq_sel [8];
    int          seq_n = 0;
    logic        req_prev = 1'b0;

    always @(negedge clk) begin
        if (cnv_req && model_on) begin
            cnv_valid = 1'b1;
            cnv_code  = par ? v1 : v0;
            par       = ~par;
        end else begin
            cnv_valid = 1'b0;
        end
        if (cnv_req && !req_prev && seq_n < 8) begin
            seq_sel[seq_n] = cnv_sel;
            seq_n++;
        end
        req_prev = cnv_req;
    end

    logic [11:0] mres [4] = '{default: '0};

    typedef struct packed {
        logic [1:0]  slot;
        logic [3:0]  sel;
        logic        avg;
        logic [1:0]  cnt;
        logic [11:0] a;
        logic [11:0] b;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{slot: 2'd0, sel: 4'd3,  avg: 1'b1, cnt: 2'd0, a: 12'd100,  b: 12'd201},
        '{slot: 2'd1, sel: 4'd7,  avg: 1'b1, cnt: 2'd3, a: 12'd4095, b: 12'd4095},
        '{slot: 2'd2, sel: 4'd12, avg: 1'b0, cnt: 2'd2, a: 12'd1234, b: 12'd0},
        '{slot: 2'd3, sel: 4'd15, avg: 1'b1, cnt: 2'd1, a: 12'd10,   b: 12'd13},
        '{slot: 2'd0, sel: 4'd0,  avg: 1'b1, cnt: 2'd2, a: 12'd0,    b: 12'd1},
        '{slot: 2'd3, sel: 4'd9,  avg: 1'b1, cnt: 2'd2, a: 12'd2000, b: 12'd3001}
    };

    function automatic logic [11:0] exp_avg(input logic avg, input logic [1:0] cnt,
                                            input logic [11:0] a, input logic [11:0] b);
        int n, lg;
        int sum;
        lg  = avg ? int'(cnt) + 2 : 0;
        n   = 1 << lg;
        sum = 0;
        for (int k = 0; k < n; k++) sum += (k % 2 == 1) ? int'(b) : int'(a);
        return 12'(sum >> lg);
    endfunction

    function automatic logic [31:0] res_word(input int hi);
        return hi ? {4'b0, mres[3], 4'b0, mres[2]} : {4'b0, mres[1], 4'b0, mres[0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(posedge clk); #2;
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_bit(input logic [ADDR_W-1:0] a, input int b, input bit val,
                            output bit ok);
        logic [31:0] d;
        ok = 0;
        for (int k = 0; k < 600 && !ok; k++) begin
            rd(a, d);
            if (d[b] == val) ok = 1;
        end
    endtask

    function automatic logic [31:0] cfg1(input bit en, input bit once, input bit avg,
                                         input logic [3:0] sel);
        logic [31:0] w;
        w = '0;
        w[31] = en; w[30] = once; w[29] = avg; w[27:24] = sel;
        return w;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        bit ok;

        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R1 reset state
        rd(A_GLOBAL, d); check(d == 32'h8000_0002, "R1 global", d, 32'h8000_0002);
        rd(A_STAT, d);   check(d == 0, "R1 status", d, 0);
        rd(A_RES_LO, d); check(d == 0, "R1 result AB", d, 0);
        rd(A_RES_HI, d); check(d == 0, "R1 result CD", d, 0);
        check(cnv_req == 0 && irq == 0, "R1 req/irq", {cnv_req, irq}, 0);

        wr(A_EVENT, 32'h000F_0F00);
        wr(A_LINE,  32'h0000_0F00);

        // R2 / R7: enable A and C while powered down
        v0 = 12'd77; v1 = 12'd77; par = 0; seq_n = 0;
        wr(slot_base(2), cfg1(1, 1, 0, 4'd5));
        wr(slot_base(0), cfg1(1, 1, 0, 4'd3));
        repeat (20) @(posedge clk);
        check(seq_n == 0, "R2 no start in power-down", seq_n, 0);
        wr(A_GLOBAL, 32'h0000_0003);
        repeat (20) @(posedge clk);
        check(seq_n == 0, "R2 no start with power-down bit", seq_n, 0);
        wr(A_GLOBAL, 32'h8000_0001);
        repeat (20) @(posedge clk);
        check(seq_n == 0, "R2 no start with clock-down bit", seq_n, 0);
        wr(A_GLOBAL, 32'h0000_0001);
        wait_bit(A_STAT, 10, 1, ok);
        check(ok, "R7 both served", ok, 1);
        check(seq_n == 2 && seq_sel[0] == 4'd3 && seq_sel[1] == 4'd5, "R7 order A then C",
              {seq_sel[0], seq_sel[1]}, {4'd3, 4'd5});
        mres[0] = 12'd77; mres[2] = 12'd77;
        rd(A_RES_LO, d); check(d == res_word(0), "R5 word AB", d, res_word(0));
        rd(A_RES_HI, d); check(d == res_word(1), "R5 word CD", d, res_word(1));
        wr(A_STAT, 32'h0);

        // vector table: R3 R4 R5 R6
        for (int v = 0; v < 6; v++) begin
            logic [11:0] e;
            int s;
            s = int'(VECS[v].slot);
            v0 = VECS[v].a; v1 = VECS[v].b; par = 0; seq_n = 0;
            wr(slot_base(s) + ADDR_W'(CFG2_OFS), {18'b0, VECS[v].cnt, 12'b0});
            wr(slot_base(s), cfg1(1, 1, VECS[v].avg, VECS[v].sel));
            wait_bit(A_STAT, B_DONE + s, 1, ok);
            check(ok, "R6 done flag", ok, 1);
            e = exp_avg(VECS[v].avg, VECS[v].cnt, VECS[v].a, VECS[v].b);
            mres[s] = e;
            rd(s < 2 ? A_RES_LO : A_RES_HI, d);
            check(d == res_word(s / 2), "R4 R5 averaged result", d, res_word(s / 2));
            check(seq_sel[0] == VECS[v].sel, "R3 input select", seq_sel[0], VECS[v].sel);
            rd(slot_base(s), d);
            check(d == cfg1(0, 1, VECS[v].avg, VECS[v].sel), "R6 enable cleared", d,
                  cfg1(0, 1, VECS[v].avg, VECS[v].sel));
            rd(slot_base(s) + ADDR_W'(CFG2_OFS), d);
            check(d == {18'b0, VECS[v].cnt, 12'b0}, "R3 count field", d,
                  {18'b0, VECS[v].cnt, 12'b0});
            wr(A_STAT, 32'h0);
        end

        // R8 timeout
        model_on = 0;
        wr(slot_base(1), cfg1(1, 1, 0, 4'd2));
        wait_bit(A_STAT, B_TMO + 1, 1, ok);
        check(ok, "R8 timeout flag", ok, 1);
        rd(A_STAT, d); check(d == 32'h0002_0000, "R8 no done flag", d, 32'h0002_0000);
        rd(slot_base(1), d); check(d[31] == 0, "R8 enable cleared", d, 0);
        rd(A_RES_LO, d); check(d == res_word(0), "R8 result unchanged", d, res_word(0));
        model_on = 1;
        wr(A_STAT, 32'h0);

        // R9 / R10 flag and line behaviour
        v0 = 12'd55; v1 = 12'd55;
        wr(slot_base(0), cfg1(1, 1, 0, 4'd1));
        wait_bit(A_STAT, B_DONE, 1, ok);
        mres[0] = 12'd55;
        @(posedge clk); #3;
        check(irq == 1, "R10 irq with line mask", irq, 1);
        rd(A_STAT, d); rd(A_STAT, d);
        check(d == 32'h0000_0100, "R9 read keeps flag", d, 32'h0000_0100);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, d); check(d == 32'h0000_0100, "R9 write 1 keeps flag", d, 32'h0000_0100);
        wr(A_LINE, 32'h0000_0E00);
        #1 check(irq == 0, "R10 irq masked", irq, 0);
        wr(A_STAT, ~32'h0000_0100);
        rd(A_STAT, d); check(d == 0, "R9 write 0 clears", d, 0);
        wr(A_LINE, 32'h0000_0F00);

        // R10 event mask blocks flag
        wr(A_EVENT, 32'h000F_0E00);
        v0 = 12'd66; v1 = 12'd66;
        wr(slot_base(0), cfg1(1, 1, 0, 4'd1));
        wait_bit(slot_base(0), 31, 0, ok);
        mres[0] = 12'd66;
        rd(A_STAT, d); check(d == 0, "R10 event mask blocks flag", d, 0);
        rd(A_RES_LO, d); check(d == res_word(0), "R10 result still stored", d, res_word(0));
        check(irq == 0, "R10 no irq", irq, 0);
        wr(A_EVENT, 32'h000F_0F00);

        // R11 continuous mode
        v0 = 12'd300; v1 = 12'd300;
        wr(slot_base(0), cfg1(1, 0, 0, 4'd4));
        wait_bit(A_STAT, B_DONE, 1, ok);
        wr(A_STAT, 32'h0);
        wait_bit(A_STAT, B_DONE, 1, ok);
        check(ok, "R11 repeated done", ok, 1);
        rd(slot_base(0), d); check(d[31] == 1, "R11 enable kept", d[31], 1);
        wr(slot_base(0), 32'h0);
        repeat (10) @(posedge clk);
        #3 check(cnv_req == 0, "R11 stops after disable", cnv_req, 0);
        mres[0] = 12'd300;
        rd(A_RES_LO, d); check(d == res_word(0), "R11 result", d, res_word(0));

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule